// File: doc/BRIEF.md
# Read-Only Instruction Fetch Bus Master

This block sits between an instruction prefetcher and a request/grant, response-valid instruction bus. The prefetcher offers fetch addresses through a valid/ready handshake. The block turns each accepted address into a word-aligned read request and holds that request until the bus grants it. It keeps at most a parameterised number of granted reads in flight, which is two by default. Responses come back in order and are passed straight to the prefetcher as data plus an error flag. The response side has no back-pressure, so every response is taken in the cycle it arrives.

Each handshake line has an odd-parity companion. The block drives the inverse of its request line. It checks the companions that arrive with grant and response-valid, and any mismatch latches an integrity alarm that stays set until reset. A flush input throws away the responses of every read still in flight, including a request that is waiting for grant at the time of the flush. This lets the prefetcher redirect without waiting for the old reads to drain. The memory-type, protection and debug-access attribute outputs are constants set by parameters.

Top module: `fetch_bus_master`

## Requirements
- R1: While reset is asserted, bus_req_o, resp_valid_o and integrity_err_o are 0 and bus_req_par_o is 1.
- R2: bus_addr_o is the accepted fetch address with its two low bits forced to 0, and the upper bits are unchanged.
- R3: Once bus_req_o is high, it stays high and bus_addr_o stays unchanged until a cycle in which bus_gnt_i is high.
- R4: bus_req_o is never high while MAX_OUT granted reads are still waiting for their responses.
- R5: bus_req_par_o is always the inverse of bus_req_o.
- R6: If bus_gnt_par_i equals bus_gnt_i, or bus_rvalid_par_i equals bus_rvalid_i, in any cycle, then integrity_err_o is 1 from the next cycle on.
- R7: integrity_err_o stays at 1 until reset and is cleared only by reset.
- R8: In a cycle with bus_rvalid_i high whose response is not discarded, resp_valid_o is 1 in that same cycle and resp_data_o and resp_err_o equal bus_rdata_i and bus_err_i. Responses are delivered in grant order.
- R9: While flush_i is high, resp_valid_o is 0. The responses of all reads granted at or before a flush cycle, and of a request still waiting for grant during that cycle, are discarded.
- R10: bus_memtype_o always equals MEM_TYPE, bus_prot_o always equals PROT, and bus_dbg_o always equals DBG_MODE.
- R11: fetch_ready_o is 1 exactly when flush_i is 0, no request is waiting (or bus_gnt_i is high this cycle), and the number of granted-but-unanswered reads plus the pending request, minus bus_rvalid_i, is below MAX_OUT. A response and a grant in the same cycle therefore free a slot at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard responses of reads in flight |
| fetch_valid_i | input | 1 | Prefetcher offers an address |
| fetch_addr_i | input | ADDR_W | Fetch address, any alignment |
| fetch_ready_o | output | 1 | Address accepted this cycle |
| bus_req_o | output | 1 | Read request |
| bus_req_par_o | output | 1 | Odd-parity companion of bus_req_o |
| bus_gnt_i | input | 1 | Request accepted by the bus |
| bus_gnt_par_i | input | 1 | Odd-parity companion of bus_gnt_i |
| bus_addr_o | output | ADDR_W | Word-aligned read address |
| bus_memtype_o | output | 2 | Memory-type attributes |
| bus_prot_o | output | 3 | Protection attributes |
| bus_dbg_o | output | 1 | Debug-mode access flag |
| bus_rvalid_i | input | 1 | Response valid |
| bus_rvalid_par_i | input | 1 | Odd-parity companion of bus_rvalid_i |
| bus_rdata_i | input | DATA_W | Response data |
| bus_err_i | input | 1 | Response error |
| resp_valid_o | output | 1 | Response passed to the prefetcher |
| resp_data_o | output | DATA_W | Response data to the prefetcher |
| resp_err_o | output | 1 | Response error to the prefetcher |
| integrity_err_o | output | 1 | Sticky parity alarm |

## Verification
The bench keeps the default 32-bit address and data widths and the default limit of two reads in flight. With that limit, a slow grant pattern combined with a three-cycle response latency pushes the block into the full state, and the zero-latency pattern exercises reuse of a slot in the same cycle it is freed. The attribute parameters are overridden with values other than their defaults (memory type 2'b10, protection 3'b101, debug flag 1), so the check on the constant outputs shows that they follow the parameters.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  function automatic logic odd_par(input logic b);
    return ~b;
  endfunction
endpackage

// File: rtl/fbm_req_ctrl.sv
module fbm_req_ctrl #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 2,
  parameter int MAX_OUT = 2,
  parameter int CNT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              gnt_i,
  input  logic              rvalid_i,
  input  logic [CNT_W-1:0]  out_cnt_i,
  output logic              fetch_ready_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              stale_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'((64'd1 << OFF_W) - 64'd1));
  localparam logic [CNT_W:0]    LIMIT      = (CNT_W+1)'(MAX_OUT);

  logic              req_q, stale_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W:0]    used, after_rsp;

  // slots held by granted reads plus the waiting request, less one retiring now
  assign used          = {1'b0, out_cnt_i} + (CNT_W+1)'(req_q);
  assign after_rsp     = used - (CNT_W+1)'(rvalid_i);
  assign fetch_ready_o = !flush_i && (!req_q || gnt_i) && (after_rsp < LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      addr_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      if (fetch_ready_o && fetch_valid_i) begin
        req_q  <= 1'b1;
        addr_q <= fetch_addr_i & ALIGN_MASK;
      end else if (gnt_i) begin
        req_q <= 1'b0;
      end
      if (flush_i)               stale_q <= req_q && !gnt_i;
      else if (gnt_i || !req_q)  stale_q <= 1'b0;
    end
  end

  assign req_o   = req_q;
  assign addr_o  = addr_q;
  assign stale_o = stale_q;

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !gnt_i) |=> (req_q && $stable(addr_q)));
endmodule

// File: rtl/fbm_txn_track.sv
module fbm_txn_track #(
  parameter int MAX_OUT = 2,
  parameter int CNT_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_i,
  input  logic             gnt_i,
  input  logic             stale_i,
  input  logic             rvalid_i,
  output logic [CNT_W-1:0] out_cnt_o,
  output logic             deliver_o
);
  logic [CNT_W-1:0] out_q, out_n, drop_q, drop_n;
  logic             take;

  assign take  = req_i && gnt_i;
  assign out_n = out_q + CNT_W'(take) - CNT_W'(rvalid_i);

  always_comb begin
    drop_n = drop_q;
    if (flush_i) begin
      drop_n = out_n;  // everything still in flight after this cycle is dropped
    end else begin
      if (take && stale_i)            drop_n = drop_n + CNT_W'(1);
      if (rvalid_i && drop_q != '0)   drop_n = drop_n - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      drop_q <= '0;
    end else begin
      out_q  <= out_n;
      drop_q <= drop_n;
    end
  end

  assign out_cnt_o = out_q;
  assign deliver_o = rvalid_i && !flush_i && (drop_q == '0);

  assert_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q == CNT_W'(MAX_OUT)) |-> !req_i);
endmodule

// File: rtl/fbm_par_chk.sv
module fbm_par_chk #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  input  logic [N-1:0] par_i,
  output logic         err_o
);
  logic [N-1:0] bad;
  logic         err_q;

  for (genvar i = 0; i < N; i++) begin : g_pair
    assign bad[i] = (par_i[i] != fbm_pkg::odd_par(sig_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q || (|bad);
  end

  assign err_o = err_q;

  assert_par_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_i != ~sig_i) |=> err_o);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/fetch_bus_master.sv
module fetch_bus_master #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          MAX_OUT  = 2,
  parameter logic [1:0]  MEM_TYPE = 2'b01,
  parameter logic [2:0]  PROT     = 3'b110,
  parameter bit          DBG_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic              bus_req_o,
  output logic              bus_req_par_o,
  input  logic              bus_gnt_i,
  input  logic              bus_gnt_par_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_memtype_o,
  output logic [2:0]        bus_prot_o,
  output logic              bus_dbg_o,
  input  logic              bus_rvalid_i,
  input  logic              bus_rvalid_par_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_err_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_err_o,
  output logic              integrity_err_o
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic             req, stale, deliver;
  logic [CNT_W-1:0] out_cnt;

  fbm_req_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_req (
    .clk_i, .rst_ni, .flush_i, .fetch_valid_i, .fetch_addr_i,
    .gnt_i(bus_gnt_i), .rvalid_i(bus_rvalid_i), .out_cnt_i(out_cnt),
    .fetch_ready_o, .req_o(req), .addr_o(bus_addr_o), .stale_o(stale)
  );

  fbm_txn_track #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni, .flush_i, .req_i(req), .gnt_i(bus_gnt_i), .stale_i(stale),
    .rvalid_i(bus_rvalid_i), .out_cnt_o(out_cnt), .deliver_o(deliver)
  );

  fbm_par_chk #(.N(2)) u_par (
    .clk_i, .rst_ni,
    .sig_i({bus_rvalid_i, bus_gnt_i}),
    .par_i({bus_rvalid_par_i, bus_gnt_par_i}),
    .err_o(integrity_err_o)
  );

  assign bus_req_o     = req;
  assign bus_req_par_o = fbm_pkg::odd_par(req);
  assign bus_memtype_o = MEM_TYPE;
  assign bus_prot_o    = PROT;
  assign bus_dbg_o     = DBG_MODE;
  assign resp_valid_o  = deliver;
  assign resp_data_o   = bus_rdata_i;
  assign resp_err_o    = bus_err_i;

  assert_resp_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (bus_rvalid_i && !flush_i));
  assert_req_par_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_par_o != bus_req_o);
endmodule

// File: tb/fetch_bus_master_tb.sv
module fetch_bus_master_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_ready_o, bus_req_o, bus_req_par_o;
  logic        bus_gnt_i = 1'b0, bus_gnt_par_i = 1'b1;
  logic [31:0] bus_addr_o;
  logic [1:0]  bus_memtype_o;
  logic [2:0]  bus_prot_o;
  logic        bus_dbg_o;
  logic        bus_rvalid_i = 1'b0, bus_rvalid_par_i = 1'b1, bus_err_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        resp_valid_o, resp_err_o, integrity_err_o;
  logic [31:0] resp_data_o;

  always #2.5 clk = ~clk;

  fetch_bus_master #(.MEM_TYPE(2'b10), .PROT(3'b101), .DBG_MODE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni, .flush_i, .fetch_valid_i, .fetch_addr_i, .fetch_ready_o,
    .bus_req_o, .bus_req_par_o, .bus_gnt_i, .bus_gnt_par_i, .bus_addr_o,
    .bus_memtype_o, .bus_prot_o, .bus_dbg_o, .bus_rvalid_i, .bus_rvalid_par_i,
    .bus_rdata_i, .bus_err_i, .resp_valid_o, .resp_data_o, .resp_err_o, .integrity_err_o
  );

  typedef struct { logic [31:0] addr; bit keep; int age; } txn_t;
  txn_t        txq[$];
  bit          pend, pend_stale, exp_int;
  logic [31:0] pend_addr, nxt_addr;
  int          n_chk, n_fail, cyc;
  int          gnt_mode, lat, flush_per, fv_mode;
  bit          inj_g, inj_r;

  function automatic logic [31:0] rdata_of(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; flush_i = 0; fetch_valid_i = 0; bus_gnt_i = 0; bus_rvalid_i = 0;
    bus_gnt_par_i = 1; bus_rvalid_par_i = 1;
    txq.delete(); pend = 0; pend_stale = 0; exp_int = 0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(bus_req_o == 0,         "R1 req",    32'(bus_req_o), 0);
      chk(bus_req_par_o == 1,     "R1 reqpar", 32'(bus_req_par_o), 1);
      chk(resp_valid_o == 0,      "R1 rvalid", 32'(resp_valid_o), 0);
      chk(integrity_err_o == 0,   "R1 R7 integ", 32'(integrity_err_o), 0);
      @(negedge clk);
    end
    rst_ni = 1'b1;
  endtask

  task automatic step();
    bit g, rv, exp_rdy, exp_rsp;
    int used;
    @(negedge clk);
    cyc++;
    flush_i       = (flush_per != 0) && (cyc % flush_per == 0);
    fetch_valid_i = (fv_mode == 0) ? 1'b1 : ((cyc / 2) % 2 == 0);
    fetch_addr_i  = nxt_addr;
    case (gnt_mode)
      0:       g = 1'b1;
      1:       g = (cyc % 2) == 0;
      default: g = (cyc % 3) == 0;
    endcase
    bus_gnt_i        = bus_req_o && g;
    rv               = (txq.size() > 0) && (txq[0].age >= lat);
    bus_rvalid_i     = rv;
    bus_rdata_i      = rv ? rdata_of(txq[0].addr) : 32'h0;
    bus_err_i        = rv ? (txq[0].addr[3] ^ txq[0].addr[6]) : 1'b0;
    bus_gnt_par_i    = ~bus_gnt_i ^ inj_g;
    bus_rvalid_par_i = ~bus_rvalid_i ^ inj_r;
    #1;
    chk(bus_req_o == pend, "R3 R11 req", 32'(bus_req_o), 32'(pend));
    if (pend) begin
      chk(bus_addr_o == pend_addr, "R2 R3 addr", bus_addr_o, pend_addr);
      chk(bus_addr_o[1:0] == 2'b00, "R2 align", 32'(bus_addr_o[1:0]), 0);
    end
    chk(!(bus_req_o && txq.size() >= 2), "R4 cap", 32'(txq.size()), 1);
    chk(bus_req_par_o == ~bus_req_o, "R5 reqpar", 32'(bus_req_par_o), 32'(~bus_req_o));
    chk({bus_memtype_o, bus_prot_o, bus_dbg_o} == {2'b10, 3'b101, 1'b1}, "R10 attr",
        32'({bus_memtype_o, bus_prot_o, bus_dbg_o}), 32'({2'b10, 3'b101, 1'b1}));
    chk(integrity_err_o == exp_int, "R6 R7 integ", 32'(integrity_err_o), 32'(exp_int));
    used    = txq.size() + int'(pend);
    exp_rdy = !flush_i && (!pend || bus_gnt_i) && (used - int'(rv) < 2);
    chk(fetch_ready_o == exp_rdy, "R11 ready", 32'(fetch_ready_o), 32'(exp_rdy));
    exp_rsp = rv && txq[0].keep && !flush_i;
    chk(resp_valid_o == exp_rsp, "R8 R9 rvalid", 32'(resp_valid_o), 32'(exp_rsp));
    if (exp_rsp) begin
      chk(resp_data_o == rdata_of(txq[0].addr), "R8 data", resp_data_o, rdata_of(txq[0].addr));
      chk(resp_err_o == (txq[0].addr[3] ^ txq[0].addr[6]), "R8 err", 32'(resp_err_o),
          32'(txq[0].addr[3] ^ txq[0].addr[6]));
    end
    // model update for the coming edge
    if (inj_g || inj_r) exp_int = 1'b1;
    if (rv) void'(txq.pop_front());
    foreach (txq[i]) txq[i].age++;
    if (pend && bus_gnt_i) begin
      txq.push_back('{addr: pend_addr, keep: !pend_stale && !flush_i, age: 0});
      pend = 0;
    end
    if (flush_i) begin
      foreach (txq[i]) txq[i].keep = 1'b0;
      if (pend) pend_stale = 1'b1;
    end
    if (fetch_valid_i && exp_rdy) begin
      pend = 1; pend_stale = 0; pend_addr = {fetch_addr_i[31:2], 2'b00};
      nxt_addr = nxt_addr + 32'd6;
    end
  endtask

  task automatic run(input int g, input int l, input int f, input int fv, input int n);
    gnt_mode = g; lat = l; flush_per = f; fv_mode = fv;
    repeat (n) step();
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; nxt_addr = 32'h1000_0003;
    inj_g = 0; inj_r = 0; exp_int = 0; pend = 0; pend_stale = 0; pend_addr = '0;
    do_reset();                 // R1
    run(0, 0, 0, 0, 200);       // full rate, same-cycle slot reuse (R11, R8)
    run(1, 3, 0, 0, 200);       // slow responses fill both slots (R4)
    run(2, 1, 0, 1, 200);       // sparse grants and fetches (R3)
    run(0, 2, 7, 0, 200);       // flushes over reads in flight (R9)
    run(2, 3, 5, 1, 200);       // flush while a request waits for grant (R9)
    inj_g = 1; step(); inj_g = 0;   // grant parity error (R6)
    run(1, 1, 0, 0, 30);            // stays set (R7)
    do_reset();                     // clears (R7)
    run(0, 1, 0, 0, 20);
    inj_r = 1; step(); inj_r = 0;   // response-valid parity error (R6)
    run(0, 1, 0, 0, 20);
    do_reset();
    run(1, 0, 0, 0, 50);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'(cyc), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule